// File: doc/BRIEF.md
# Hall Commutation Decoder with Tach Output

This block turns the three squared Hall-sensor levels of a brushless motor into the switch selection for a three-phase bridge. For every valid Hall code it names one phase whose upper switch is held fully on and one other phase whose lower switch carries the PWM. A direction input selects forward or reverse rotation. Reverse rotation is obtained by decoding the bitwise complement of the Hall code. A single tach signal is derived from the parity of the three Hall levels.

The Hall levels come from asynchronous comparators. They pass through a synchroniser chain and then a two-sample agreement filter before they reach the decoder, so a one-cycle glitch never reaches the bridge. All outputs are registered. The two codes that cannot occur on a healthy sensor set (all low, all high) switch every output off and raise an invalid flag.

Top module: `hall_commutator`

## Requirements
- R1: With `fwd_dir` = 1, the code {hall[0],hall[1],hall[2]} = 101 selects upper V and lower U. 100 selects upper W and lower U. 110 selects upper W and lower V. 010 selects upper U and lower V. 011 selects upper U and lower W. 001 selects upper V and lower W. Select bit 0 is phase U, bit 1 is V and bit 2 is W.
- R2: With `fwd_dir` = 0, each code produces the pair that R1 gives for its bitwise complement; for example 010 selects upper V and lower U.
- R3: Codes 000 and 111 drive both select vectors to zero and set `hall_invalid` to 1. Every other code leaves `hall_invalid` at 0.
- R4: `fg_out` is the inverted odd parity of the three filtered Hall levels. It is 1 for 101, 110, 011 and 000, and 0 for 100, 010, 001 and 111.
- R5: While `enable` is 0, both select vectors are zero, and `fg_out` and `hall_invalid` still follow the Hall code.
- R6: A Hall code that holds for only one clock cycle after synchronisation never reaches the outputs. A code that holds for two cycles is accepted.
- R7: A Hall input change reaches the outputs on the 5th rising clock edge after it is applied (SYNC_STAGES + 3). A change on `enable` or `fwd_dir` reaches the outputs on the 1st edge.
- R8: While `rst_n` is 0, every output is 0 after a clock edge.
- R9: `upper_sel` and `lower_sel` each have at most one bit set, and they never select the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_raw | input | 3 | Squared Hall levels; bit 0 is the first sensor |
| fwd_dir | input | 1 | 1 selects forward, 0 selects reverse |
| enable | input | 1 | 0 forces both select vectors to zero |
| upper_sel | output | 3 | One-hot upper switch held on (U, V, W) |
| lower_sel | output | 3 | One-hot lower switch carrying PWM (U, V, W) |
| hall_invalid | output | 1 | Hall code is 000 or 111 |
| fg_out | output | 1 | Tach output, inverted odd parity of the Hall code |

## Verification
A Hall change is due at the outputs five rising edges after it is applied. Direction and enable changes are due one edge after they are applied. The random and directed cases therefore hold every stimulus for six cycles and sample at the falling edge after that. In one directed case the outputs are sampled after the 4th edge, where they must still show the old code, and after the 5th edge, where they must show the new one. The glitch cases watch every falling edge in the window where a one-cycle pulse could appear, and they confirm that a two-cycle pulse shows up at the outputs for exactly two cycles.

// File: rtl/hall_pkg.sv
// hall_pkg: shared phase indices and the decoded drive record.
// Assumes three phases; select vectors are indexed U=0, V=1, W=2.
package hall_pkg;
    localparam int NUM_PHASES = 3;
    localparam int PH_U = 0;
    localparam int PH_V = 1;
    localparam int PH_W = 2;

    typedef struct packed {
        logic [NUM_PHASES-1:0] upper;
        logic [NUM_PHASES-1:0] lower;
        logic                  invalid;
        logic                  fg;
    } hall_drive_t;
endpackage

// File: rtl/hall_input_filter.sv
// hall_input_filter: synchronises asynchronous Hall levels through a
// SYNC_STAGES flop chain, then accepts a new code only after two equal
// consecutive synchronised samples.
// Assumes the inputs are already squared digital levels.
module hall_input_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int WIDTH       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] stable_out
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [WIDTH-1:0] chain_q [SYNC_STAGES];
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] stable_q;

    // First synchroniser stage samples the raw levels.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= raw_in;
    end

    // Remaining synchroniser stages.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Agreement filter: update the stable code only on two equal samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            stable_q <= '0;
        end else begin
            prev_q <= chain_q[LAST];
            if (chain_q[LAST] == prev_q) stable_q <= chain_q[LAST];
        end
    end

    assign stable_out = stable_q;

    // R6: the stable code moves only when the last two samples agreed.
    p_filter_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stable_q != $past(stable_q)) |-> ($past(chain_q[LAST]) == $past(prev_q)));
endmodule

// File: rtl/hall_pair_decoder.sv
// hall_pair_decoder: combinational map from a filtered Hall code and the
// direction to the upper/lower switch pair, invalid flag and tach level.
// Assumes code bit 0 is the first sensor; reverse decodes the complement.
module hall_pair_decoder
    import hall_pkg::*;
(
    input  logic [2:0]  code,
    input  logic        fwd,
    output hall_drive_t drive
);
    logic [2:0] eff;
    logic [2:0] ord;

    // Effective code: complement for reverse rotation, sensor 1 in the MSB.
    always_comb begin
        eff = fwd ? code : ~code;
        ord = {eff[0], eff[1], eff[2]};
    end

    // Pair selection, invalid detection and tach parity.
    always_comb begin
        drive         = '0;
        drive.fg      = ~(^code);
        drive.invalid = (code == 3'b000) || (code == 3'b111);
        case (ord)
            3'b101: begin drive.upper[PH_V] = 1'b1; drive.lower[PH_U] = 1'b1; end
            3'b100: begin drive.upper[PH_W] = 1'b1; drive.lower[PH_U] = 1'b1; end
            3'b110: begin drive.upper[PH_W] = 1'b1; drive.lower[PH_V] = 1'b1; end
            3'b010: begin drive.upper[PH_U] = 1'b1; drive.lower[PH_V] = 1'b1; end
            3'b011: begin drive.upper[PH_U] = 1'b1; drive.lower[PH_W] = 1'b1; end
            3'b001: begin drive.upper[PH_V] = 1'b1; drive.lower[PH_W] = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/hall_commutator.sv
// hall_commutator: top level. Filters the Hall levels, decodes the switch
// pair and registers all outputs; enable gates only the select vectors.
// Assumes synchronous active-low reset and a single clock domain.
module hall_commutator
    import hall_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] hall_raw,
    input  logic                  fwd_dir,
    input  logic                  enable,
    output logic [NUM_PHASES-1:0] upper_sel,
    output logic [NUM_PHASES-1:0] lower_sel,
    output logic                  hall_invalid,
    output logic                  fg_out
);
    logic [NUM_PHASES-1:0] code_stable;
    hall_drive_t           drive;

    hall_input_filter #(.SYNC_STAGES(SYNC_STAGES), .WIDTH(NUM_PHASES)) i_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (hall_raw),
        .stable_out (code_stable)
    );

    hall_pair_decoder i_decode (
        .code  (code_stable),
        .fwd   (fwd_dir),
        .drive (drive)
    );

    // Output register: gate selects by enable, pass tach and invalid through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_sel    <= '0;
            lower_sel    <= '0;
            hall_invalid <= 1'b0;
            fg_out       <= 1'b0;
        end else begin
            upper_sel    <= enable ? drive.upper : '0;
            lower_sel    <= enable ? drive.lower : '0;
            hall_invalid <= drive.invalid;
            fg_out       <= drive.fg;
        end
    end

    // R9: at most one upper and one lower switch selected.
    p_upper_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upper_sel) && $onehot0(lower_sel));
    // R9: never upper and lower on the same phase.
    p_no_shoot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_sel & lower_sel) == '0);
    // R3: invalid code means all switches off.
    p_invalid_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hall_invalid |-> (upper_sel == '0 && lower_sel == '0));
    // R5: disabled means both select vectors zero on the next cycle.
    p_enable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (upper_sel == '0 && lower_sel == '0));
    // R4: tach is the inverted parity of the filtered code one cycle earlier.
    p_fg_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fg_out == ~(^$past(code_stable))));
endmodule

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_raw = 3'b000;
    logic       fwd_dir = 1'b1;
    logic       enable = 1'b0;
    logic [2:0] upper_sel, lower_sel;
    logic       hall_invalid, fg_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    hall_commutator i_hall_commutator (
        .clk(clk), .rst_n(rst_n), .hall_raw(hall_raw), .fwd_dir(fwd_dir),
        .enable(enable), .upper_sel(upper_sel), .lower_sel(lower_sel),
        .hall_invalid(hall_invalid), .fg_out(fg_out)
    );

    // Expected {invalid, fg, upper[2:0], lower[2:0]} from the requirements.
    function automatic logic [7:0] model(input logic [2:0] c, input logic fwd, input logic en);
        logic [2:0] e, o, up, lo;
        e = fwd ? c : ~c;
        o = {e[0], e[1], e[2]};
        up = 3'b000; lo = 3'b000;
        case (o)
            3'b101: begin up = 3'b010; lo = 3'b001; end
            3'b100: begin up = 3'b100; lo = 3'b001; end
            3'b110: begin up = 3'b100; lo = 3'b010; end
            3'b010: begin up = 3'b001; lo = 3'b010; end
            3'b011: begin up = 3'b001; lo = 3'b100; end
            3'b001: begin up = 3'b010; lo = 3'b100; end
            default: ;
        endcase
        if (!en) begin up = 3'b000; lo = 3'b000; end
        return {(c == 3'b000 || c == 3'b111), ~(^c), up, lo};
    endfunction

    task automatic check(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {hall_invalid, fg_out, upper_sel, lower_sel};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (hall=%b fwd=%b en=%b)",
                     req, act, exp, hall_raw, fwd_dir, enable);
        end
    endtask

    task automatic apply_hold(input logic [2:0] c, input logic fwd, input logic en);
        @(negedge clk);
        hall_raw = c; fwd_dir = fwd; enable = en;
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset", 8'b0000_0000);
        rst_n = 1'b1;

        // R1 forward mapping, every code
        for (int c = 0; c < 8; c++) begin
            apply_hold(c[2:0], 1'b1, 1'b1);
            check((c == 0 || c == 7) ? "R3 invalid fwd" : "R1 fwd map", model(c[2:0], 1'b1, 1'b1));
        end
        // R2 reverse mapping, every code
        for (int c = 0; c < 8; c++) begin
            apply_hold(c[2:0], 1'b0, 1'b1);
            check((c == 0 || c == 7) ? "R3 invalid rev" : "R2 rev map", model(c[2:0], 1'b0, 1'b1));
        end
        // R2 example: hall[0..2]=0,1,0 reverse gives upper V lower U
        apply_hold(3'b010, 1'b0, 1'b1);
        check("R2 example", {1'b0, 1'b0, 3'b010, 3'b001});
        // R5 enable low still reports fg and invalid
        apply_hold(3'b101, 1'b1, 1'b0);
        check("R5 disabled", model(3'b101, 1'b1, 1'b0));
        apply_hold(3'b000, 1'b1, 1'b0);
        check("R5 disabled fg R4", {1'b1, 1'b1, 6'b0});

        // R7 latency of a Hall change: old after 4 edges, new after 5
        apply_hold(3'b001, 1'b1, 1'b1);
        @(negedge clk); hall_raw = 3'b011;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7 before edge5", model(3'b001, 1'b1, 1'b1));
        @(negedge clk);
        check("R7 at edge5", model(3'b011, 1'b1, 1'b1));
        // R7 enable change after one edge
        enable = 1'b0;
        @(negedge clk);
        check("R7 enable 1 edge", model(3'b011, 1'b1, 1'b0));
        enable = 1'b1; fwd_dir = 1'b0;
        @(negedge clk);
        check("R7 dir 1 edge", model(3'b011, 1'b0, 1'b1));

        // R6 one-cycle glitch rejected
        apply_hold(3'b100, 1'b1, 1'b1);
        hall_raw = 3'b110;
        @(negedge clk); hall_raw = 3'b100;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check("R6 glitch ignored", model(3'b100, 1'b1, 1'b1));
        end
        // R6 two-cycle pulse accepted, seen for two cycles
        begin
            int seen;
            seen = 0;
            hall_raw = 3'b110;
            @(negedge clk); @(negedge clk); hall_raw = 3'b100;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if ({hall_invalid, fg_out, upper_sel, lower_sel} == model(3'b110, 1'b1, 1'b1)) seen++;
            end
            n_tests++;
            if (seen != 2) begin
                n_fail++;
                $display("FAIL R6 pulse: got %0d cycles expected 2", seen);
            end
        end

        // Random mix (R1 R2 R3 R4 R5 R9)
        for (int i = 0; i < 300; i++) begin
            logic [2:0] c;
            logic f, en;
            c  = 3'($urandom_range(0, 7));
            f  = 1'($urandom_range(0, 1));
            en = ($urandom_range(0, 3) != 0);
            apply_hold(c, f, en);
            check("R1/R2 random", model(c, f, en));
            n_tests++;
            if ((upper_sel & lower_sel) != 3'b000 || $countones(upper_sel) > 1) begin
                n_fail++;
                $display("FAIL R9: got up=%b lo=%b expected disjoint one-hot", upper_sel, lower_sel);
            end
        end

        // R8 reset mid-run
        apply_hold(3'b101, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset again", 8'b0000_0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule